// File: doc/BRIEF.md
# SPI Register Access Slave for PWM Settings

This block is an SPI slave (mode 0, framed by an active-low chip select) that lets a host read and write a bank of sixteen-bit registers. Each PWM channel owns two of these registers: one for duty and one for frequency. The block brings SCLK, chip select and MOSI into the system clock domain through short synchronizers. It sees SCLK edges as transitions of the synchronized copy, and it shifts bytes most significant bit first. The whole bank is exported as two flat buses that the PWM generator reads directly.

Every frame starts with a command byte. A write-type command is followed by a big-endian 16-bit address word. The top bit of that word decides whether a following big-endian 16-bit data word is committed to the register or whether the frame only sets the read pointer. A read is done as two frames. The first is a write-type frame that sets the pointer. The second is a one-byte read command, after which the slave returns 32 bits. The final 16 of those bits carry the pointed-to register. A status command returns a fixed identification word in the same bit positions. Each committed write also raises a one-cycle strobe towards the PWM side, together with the register index and value.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset every register reads zero on `duty_o` and `freq_o`, and `spi_miso` and `wr_stb` are low.
- R2: A frame with command bit 6 set and bit 7 clear, followed by address word A with A[15]=1 and data word D (both big-endian), sets register A[14:0] to D. Command bits 5..0 have no effect.
- R3: Any write-type frame latches A[14:0] as the read pointer once its third byte completes. When A[15]=0, no register changes and no strobe is raised.
- R4: After a command byte with bit 7 set and bit 6 clear, the slave shifts out 32 bits MSB first. Bits 15..0 of that stream hold the register at the read pointer. Command bits 5..0 have no effect.
- R5: After a command byte with bits 7 and 6 both set, the final 16 bits of the 32-bit response equal the STATUS_WORD parameter (default 0x5AC3).
- R6: Register 2n drives duty slice n (`duty_o[16n+15:16n]`) and register 2n+1 drives frequency slice n, for n = 0..NUM_CH-1.
- R7: Writes to an address with A[14:0] >= 2*NUM_CH change nothing and raise no strobe. Reads from such an address return zero.
- R8: Raising chip select before a write frame's fifth byte completes discards the frame. The next frame is decoded from its first byte.
- R9: Each committed write raises `wr_stb` for exactly one clock, with `wr_addr`/`wr_data` giving the register and value. Both stay unchanged until the next commit.
- R10: A command byte with bits 7 and 6 both clear changes no register, raises no strobe and leaves `spi_miso` low for the rest of the frame.
- R11: `spi_miso` changes only in response to a falling SCLK edge or to chip select going high. It is stable while SCLK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| duty_o | output | NUM_CH*DW | Duty registers, slice n = register 2n |
| freq_o | output | NUM_CH*DW | Frequency registers, slice n = register 2n+1 |
| wr_stb | output | 1 | One-cycle pulse per committed write |
| wr_addr | output | $clog2(2*NUM_CH) | Index of last committed register |
| wr_data | output | DW | Value of last committed write |

## Verification
Every register is written with an arithmetic value pattern and then with its bitwise inverse. Each value is read back through both a separate pointer frame and the pointer left by the write itself. Together these separate a wrong duty/frequency mapping, stuck data bits and a pointer that is not latched on committing writes. Non-committing address frames, out-of-range addresses (just past the bank and at the top of the 15-bit space) and commands with reserved bits set or with neither access bit set tell ignored traffic apart from real writes. Frames cut short by chip select and status reads with different reserved bits check the framing and the response path. MISO is sampled at both ends of each high SCLK phase.

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave #(
  parameter int NUM_CH = 16,
  parameter int DW = 16,
  parameter int SYNC = 2,
  parameter logic [15:0] STATUS_WORD = 16'h5AC3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sclk,
  input  logic                 spi_cs_n,
  input  logic                 spi_mosi,
  output logic                 spi_miso,
  output logic [NUM_CH*DW-1:0] duty_o,
  output logic [NUM_CH*DW-1:0] freq_o,
  output logic                 wr_stb,
  output logic [$clog2(2*NUM_CH)-1:0] wr_addr,
  output logic [DW-1:0]        wr_data
);
  localparam int NREG = 2 * NUM_CH;
  localparam int AW = $clog2(NREG);
  localparam int TXW = 2 * DW;
  localparam logic [14:0] NREG_W = 15'(NREG);

  logic [SYNC-1:0] sclk_sy, cs_sy, mosi_sy;
  logic sclk_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      cs_sy   <= '1;
      mosi_sy <= '0;
      sclk_d  <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[SYNC-2:0], spi_sclk};
      cs_sy   <= {cs_sy[SYNC-2:0], spi_cs_n};
      mosi_sy <= {mosi_sy[SYNC-2:0], spi_mosi};
      sclk_d  <= sclk_sy[SYNC-1];
    end
  end

  wire sclk_s = sclk_sy[SYNC-1];
  wire cs_act = ~cs_sy[SYNC-1];
  wire rise   = cs_act & sclk_s & ~sclk_d;
  wire fall   = cs_act & ~sclk_s & sclk_d;

  logic [2:0] bit_cnt, byte_cnt;
  logic [6:0] rx_sr;
  logic [7:0] cmd, addr_hi, data_hi;
  logic [15:0] addr_word;
  logic [14:0] rd_ptr;
  logic [DW-1:0] bank [NREG];
  logic [DW-1:0] tx_load;
  logic [TXW-1:0] tx_sr;
  logic load_pend;

  wire [7:0] rx_byte  = {rx_sr, mosi_sy[SYNC-1]};
  wire byte_done      = rise & (bit_cnt == 3'd7);
  wire cmd_wr         = cmd[6] & ~cmd[7];
  wire wr_in_range    = addr_word[14:0] < NREG_W;
  wire commit         = byte_done & (byte_cnt == 3'd4) & cmd_wr & addr_word[15] & wr_in_range;
  wire [DW-1:0] rd_val = (rd_ptr < NREG_W) ? bank[rd_ptr[AW-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      rx_sr     <= '0;
      cmd       <= '0;
      addr_hi   <= '0;
      data_hi   <= '0;
      addr_word <= '0;
      rd_ptr    <= '0;
    end else if (!cs_act) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      cmd      <= '0;
    end else if (rise) begin
      rx_sr   <= rx_byte[6:0];
      bit_cnt <= bit_cnt + 3'd1;
      if (byte_done) begin
        if (byte_cnt != 3'd5) byte_cnt <= byte_cnt + 3'd1;
        case (byte_cnt)
          3'd0: cmd <= rx_byte;
          3'd1: addr_hi <= rx_byte;
          3'd2: begin
            addr_word <= {addr_hi, rx_byte};
            if (cmd_wr) rd_ptr <= {addr_hi[6:0], rx_byte};
          end
          3'd3: data_hi <= rx_byte;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= commit;
      if (commit) begin
        bank[addr_word[AW-1:0]] <= {data_hi, rx_byte};
        wr_addr <= addr_word[AW-1:0];
        wr_data <= {data_hi, rx_byte};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr     <= '0;
      tx_load   <= '0;
      load_pend <= 1'b0;
    end else if (!cs_act) begin
      tx_sr     <= '0;
      load_pend <= 1'b0;
    end else begin
      if (byte_done && byte_cnt == 3'd0) begin
        load_pend <= rx_byte[7];
        tx_load   <= rx_byte[6] ? STATUS_WORD : rd_val;
      end
      if (fall) begin
        if (load_pend) begin
          tx_sr     <= {{DW{1'b0}}, tx_load};
          load_pend <= 1'b0;
        end else begin
          tx_sr <= {tx_sr[TXW-2:0], 1'b0};
        end
      end
    end
  end

  assign spi_miso = tx_sr[TXW-1];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign duty_o[n*DW +: DW] = bank[2*n];
    assign freq_o[n*DW +: DW] = bank[2*n+1];
  end

  p_stb_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  p_stb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> ($stable(wr_addr) && $stable(wr_data)));
  p_bank_only_on_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(duty_o) || !$stable(freq_o)) |-> wr_stb);
  p_stb_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (32'(wr_addr) < NREG));
  p_miso_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_miso) |-> !sclk_s);
  p_idle_miso_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !spi_miso);
endmodule

// File: tb/spi_regbank_slave_bench.sv
module spi_regbank_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 6;
  localparam int NUM_CH = 16;
  localparam int NREG = 2 * NUM_CH;
  localparam logic [15:0] STATUS = 16'h5AC3;

  logic clk = 0, rst_n = 0;
  logic spi_sclk = 0, spi_cs_n = 1, spi_mosi = 0;
  logic spi_miso, wr_stb;
  logic [NUM_CH*16-1:0] duty_o, freq_o;
  logic [4:0] wr_addr;
  logic [15:0] wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regbank_slave u_spi_regbank_slave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .duty_o(duty_o), .freq_o(freq_o),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

  int checks = 0, fails = 0, stb_cnt = 0, stb_wide = 0, miso_glitch = 0;
  logic stb_prev = 0;
  logic [15:0] model [NREG];
  bit done = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (wr_stb) stb_cnt <= stb_cnt + 1;
      if (wr_stb && stb_prev) stb_wide <= stb_wide + 1;
      stb_prev <= wr_stb;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      repeat (H) @(negedge clk);
      rx[i] = spi_miso;
      spi_sclk = 1;
      repeat (H) @(negedge clk);
      if (spi_miso !== rx[i]) miso_glitch++;
      spi_sclk = 0;
    end
  endtask

  task automatic cs_lo();
    spi_cs_n = 0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (H) @(negedge clk);
    spi_cs_n = 1;
    repeat (2*H + 4) @(negedge clk);
  endtask

  task automatic wr_frame(input logic [7:0] c, input logic [15:0] a, input logic [15:0] d);
    logic [7:0] r;
    cs_lo();
    xfer(c, r); xfer(a[15:8], r); xfer(a[7:0], r); xfer(d[15:8], r); xfer(d[7:0], r);
    cs_hi();
  endtask

  task automatic ptr_frame(input logic [15:0] a);
    logic [7:0] r;
    cs_lo();
    xfer(8'h40, r); xfer(a[15:8], r); xfer(a[7:0], r);
    cs_hi();
  endtask

  task automatic rd_frame(input logic [7:0] c, output logic [31:0] v);
    logic [7:0] b0, b1, b2, b3, r;
    cs_lo();
    xfer(c, r); xfer(8'h00, b0); xfer(8'h00, b1); xfer(8'h00, b2); xfer(8'h00, b3);
    cs_hi();
    v = {b0, b1, b2, b3};
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h03B1 + 16'h1C07) ^ (a << 9));
  endfunction

  task automatic check_bank(input string req);
    for (int a = 0; a < NREG; a++) begin
      logic [15:0] v;
      v = a[0] ? freq_o[(a/2)*16 +: 16] : duty_o[(a/2)*16 +: 16];
      check(req, {16'h0, v}, {16'h0, model[a]});
    end
  endtask

  initial begin
    logic [31:0] v;
    int s0;
    for (int a = 0; a < NREG; a++) model[a] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 miso", {31'h0, spi_miso}, 0);
    check("R1 stb", {31'h0, wr_stb}, 0);
    check_bank("R1 bank");

    // R2 R3 R4 R6 R9: sweep all registers, readback via pointer frame
    for (int a = 0; a < NREG; a++) begin
      s0 = stb_cnt;
      wr_frame(8'h40, 16'h8000 | 16'(a), pat(a));
      model[a] = pat(a);
      check("R9 one strobe", stb_cnt - s0, 1);
      check("R9 addr/data", {11'h0, wr_addr, wr_data}, {11'h0, 5'(a), pat(a)});
      ptr_frame(16'(a));
      rd_frame(8'h80, v);
      check("R4 readback", {16'h0, v[15:0]}, {16'h0, pat(a)});
      check("R9 hold", {11'h0, wr_addr, wr_data}, {11'h0, 5'(a), pat(a)});
    end
    check_bank("R6 mapping");

    // R3: pointer left by committing write; inverse pattern, reserved cmd bits set
    for (int a = NREG - 1; a >= 0; a--) begin
      wr_frame(8'h7F, 16'h8000 | 16'(a), ~pat(a));
      model[a] = ~pat(a);
      rd_frame(8'hBF, v);
      check("R3 ptr after write / R2 reserved", {16'h0, v[15:0]}, {16'h0, ~pat(a)});
    end
    check_bank("R6 inverse");

    // R3: bit15 clear leaves register unchanged
    s0 = stb_cnt;
    wr_frame(8'h40, 16'h0005, 16'hDEAD);
    check("R3 no strobe", stb_cnt - s0, 0);
    check_bank("R3 unchanged");
    rd_frame(8'h80, v);
    check("R3 ptr read", {16'h0, v[15:0]}, {16'h0, model[5]});

    // R7 out of range
    s0 = stb_cnt;
    wr_frame(8'h40, 16'h8000 | 16'(NREG), 16'hBEEF);
    wr_frame(8'h40, 16'hFFFF, 16'h1234);
    check("R7 no strobe", stb_cnt - s0, 0);
    check_bank("R7 unchanged");
    ptr_frame(16'(NREG));
    rd_frame(8'h80, v);
    check("R7 read zero", v, 0);
    ptr_frame(16'h7FFF);
    rd_frame(8'h80, v);
    check("R7 read zero top", v, 0);

    // R5 status
    rd_frame(8'hC0, v);
    check("R5 status", {16'h0, v[15:0]}, {16'h0, STATUS});
    rd_frame(8'hFF, v);
    check("R5 status reserved", {16'h0, v[15:0]}, {16'h0, STATUS});

    // R8 abort mid-frame
    begin
      logic [7:0] r;
      s0 = stb_cnt;
      cs_lo();
      xfer(8'h40, r); xfer(8'h80, r); xfer(8'h03, r); xfer(8'h55, r);
      cs_hi();
      check("R8 abort no strobe", stb_cnt - s0, 0);
      check_bank("R8 abort unchanged");
      cs_lo();
      xfer(8'h40, r); xfer(8'h80, r); xfer(8'h03, r); xfer(8'h55, r);
      xfer(8'hAA, r); xfer(8'h00, r);
      spi_cs_n = 1;
      repeat (2) @(negedge clk);
      spi_cs_n = 0;
      repeat (H) @(negedge clk);
      xfer(8'h40, r); xfer(8'h80, r); xfer(8'h07, r); xfer(8'h12, r); xfer(8'h34, r);
      cs_hi();
      model[3] = 16'h55AA;
      model[7] = 16'h1234;
      check("R8 refresh strobes", stb_cnt - s0, 2);
      check_bank("R8 fresh frame");
    end

    // R10 neither bit
    begin
      logic [7:0] r, acc;
      s0 = stb_cnt;
      acc = 0;
      cs_lo();
      xfer(8'h3F, r); xfer(8'h80, r); acc |= r; xfer(8'h02, r); acc |= r;
      xfer(8'hFF, r); acc |= r; xfer(8'hFF, r); acc |= r;
      cs_hi();
      check("R10 no strobe", stb_cnt - s0, 0);
      check("R10 miso low", {24'h0, acc}, 0);
      check_bank("R10 unchanged");
    end

    check("R9 strobe width", stb_wide, 0);
    check("R11 miso stable while sclk high", miso_glitch, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule